// File: doc/BRIEF.md
# Double-Buffered Serial Converter Register Front End

This block is the digital side of a 12-bit voltage-output converter. A host writes 16-bit frames over a four-wire serial port. The frame select `sync_n` is active low. Data bits are sampled on falling edges of `sclk`, most significant bit first. The top four bits of a frame are a command code and the lower twelve bits are data. A write lands first in a staging (input) register. It reaches the converter code register `dac_code` when a load strobe falls. It can also get there at once, when the load strobe is held low through the write.

A separate clear line zeroes both registers. While that line is low, the load strobe is ignored. Read commands queue the converter code or the control word for return on `sdo` during the following frame. An over-temperature indication from the sensor is passed out as an active-low alarm.

All serial and strobe inputs are asynchronous to `clk`. They pass through a two-stage synchronizer, and the block acts on the edges it detects afterwards. The serial clock must therefore stay below roughly a sixth of `clk`.

Top module: `dac_serial_front`

## Requirements
- R1: After `rst` is high for one `clk` edge, `dac_code`, `ctrl_word` and `sdo` are 0 and `alarm_n` is 1.
- R2: A frame is 16 bits, sampled MSB first on `sclk` falling edges while `sync_n` is low. Bits [15:12] are the command and bits [11:0] are the data. Command 0x1 writes only the input register; `dac_code` does not change.
- R3: If `sync_n` rises before the 16th falling edge, the frame is dropped and no register changes.
- R4: A falling edge of `ldac_n` while `clr_n` is high copies the input register into `dac_code`.
- R5: If `ldac_n` is low when a command 0x1 frame completes, `dac_code` takes the new data directly.
- R6: A falling edge of `clr_n` sets the input register and `dac_code` to 0.
- R7: While `clr_n` is low, `ldac_n` edges do not change `dac_code`, and command 0x1 frames still write the input register.
- R8: Command 0x2 writes the data into `ctrl_word`. `ctrl_word` changes only on a completed frame, or on reset.
- R9: Command 0x9 queues `{4'h0, dac_code}`. It is shifted out on `sdo` during the next frame, MSB first. The MSB is valid before the first falling edge, and each later bit appears after an `sclk` rising edge.
- R10: Command 0xA queues `{4'h0, ctrl_word}` for return in the same way.
- R11: `sdo` is 0 outside frames and during any frame with no queued read.
- R12: `alarm_n` is the inverse of `over_temp`, after synchronization and one register.
- R13: Command codes other than 0x1, 0x2, 0x9 and 0xA change no register.
- R14: `sclk` falling edges after the 16th in the same frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idles high |
| sync_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial readback data |
| ldac_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low clear |
| over_temp | input | 1 | Over-temperature indication, active high |
| alarm_n | output | 1 | Active-low alarm |
| dac_code | output | 12 | Converter code register |
| ctrl_word | output | 12 | Control register |

## Verification
A mis-counted bit position shows up after the next load strobe as a shifted or corrupted `dac_code`. It also shows up as a readback word that differs from the written one. Both appear within one frame plus a few `clk` cycles. A stale abort or clear path leaves an old code on `dac_code` after a strobe that should have been ignored, or that should have loaded zero. A misaligned readback shifter shows a wrong `sdo` bit on the very first falling edge of the following frame.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP      = 4'h0,
    CMD_WR_INPUT = 4'h1,
    CMD_WR_CTRL  = 4'h2,
    CMD_RD_DAC   = 4'h9,
    CMD_RD_CTRL  = 4'hA
  } cmd_e;
endpackage

// File: rtl/dsf_sync.sv
module dsf_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/dsf_frame_rx.sv
module dsf_frame_rx #(
  parameter int FRAME_W = 16,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               sync_s,
  input  logic               sdi_s,
  output logic               frame_start,
  output logic               frame_done,
  output logic [FRAME_W-1:0] frame_word,
  output logic               sclk_rise,
  output logic               sclk_fall,
  output logic               in_frame
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic             sclk_q, sync_q, active;
  logic [CNT_W-1:0] cnt;

  assign sclk_fall = sclk_q & ~sclk_s;
  assign sclk_rise = ~sclk_q & sclk_s;
  assign in_frame  = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q      <= 1'b1;
      sync_q      <= 1'b1;
      active      <= 1'b0;
      cnt         <= '0;
      frame_word  <= '0;
      frame_start <= 1'b0;
      frame_done  <= 1'b0;
    end else begin
      sclk_q      <= sclk_s;
      sync_q      <= sync_s;
      frame_start <= 1'b0;
      frame_done  <= 1'b0;
      if (sync_s) begin
        active <= 1'b0;                      // idle or early abort
      end else if (sync_q) begin
        active      <= 1'b1;                 // select just fell
        cnt         <= '0;
        frame_start <= 1'b1;
      end else if (active && sclk_fall) begin
        frame_word <= {frame_word[FRAME_W-2:0], sdi_s};
        cnt        <= cnt + 1'b1;
        if (cnt == LAST) begin
          active     <= 1'b0;                // later edges ignored
          frame_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dsf_regs.sv
module dsf_regs
  import dsf_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int FRAME_W = DATA_W + CMD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_done,
  input  logic [FRAME_W-1:0] frame_word,
  input  logic               ldac_s,
  input  logic               clr_s,
  output logic [DATA_W-1:0]  dac_code,
  output logic [DATA_W-1:0]  ctrl_word,
  output logic               rb_load,
  output logic [FRAME_W-1:0] rb_value,
  output logic               ldac_fall,
  output logic               clr_fall
);
  logic              ldac_q, clr_q;
  logic [DATA_W-1:0] inp;
  cmd_e              cmd;
  logic [DATA_W-1:0] data;

  assign ldac_fall = ldac_q & ~ldac_s;
  assign clr_fall  = clr_q & ~clr_s;
  assign cmd       = cmd_e'(frame_word[FRAME_W-1 -: CMD_W]);
  assign data      = frame_word[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ldac_q    <= 1'b1;
      clr_q     <= 1'b1;
      inp       <= '0;
      dac_code  <= '0;
      ctrl_word <= '0;
      rb_load   <= 1'b0;
      rb_value  <= '0;
    end else begin
      ldac_q  <= ldac_s;
      clr_q   <= clr_s;
      rb_load <= 1'b0;
      if (frame_done) begin
        case (cmd)
          CMD_WR_INPUT: begin
            inp <= data;
            if (!ldac_s && clr_s) dac_code <= data;   // strobe tied low
          end
          CMD_WR_CTRL: ctrl_word <= data;
          CMD_RD_DAC: begin
            rb_load  <= 1'b1;
            rb_value <= FRAME_W'(dac_code);
          end
          CMD_RD_CTRL: begin
            rb_load  <= 1'b1;
            rb_value <= FRAME_W'(ctrl_word);
          end
          default: ;
        endcase
      end else if (ldac_fall && clr_s) begin
        dac_code <= inp;
      end
      if (clr_fall) begin
        inp      <= '0;
        dac_code <= '0;
      end
    end
  end
endmodule

// File: rtl/dsf_readback.sv
module dsf_readback #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rb_load,
  input  logic [FRAME_W-1:0] rb_value,
  input  logic               frame_start,
  input  logic               in_frame,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  output logic               sdo
);
  logic [FRAME_W-1:0] hold, out_sh;
  logic               pending, armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      out_sh  <= '0;
      pending <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (frame_start) begin
        out_sh  <= pending ? hold : '0;
        pending <= 1'b0;
        armed   <= 1'b0;
      end else if (!in_frame) begin
        out_sh <= '0;
        armed  <= 1'b0;
      end else begin
        if (sclk_fall) armed <= 1'b1;
        if (sclk_rise && armed) out_sh <= {out_sh[FRAME_W-2:0], 1'b0};
      end
      if (rb_load) begin
        hold    <= rb_value;
        pending <= 1'b1;
      end
    end
  end

  assign sdo = out_sh[FRAME_W-1];
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dsf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_W = DATA_W + CMD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              sdi,
  output logic              sdo,
  input  logic              ldac_n,
  input  logic              clr_n,
  input  logic              over_temp,
  output logic              alarm_n,
  output logic [DATA_W-1:0] dac_code,
  output logic [DATA_W-1:0] ctrl_word
);
  logic               sclk_s, sync_s, sdi_s, ldac_s, clr_s, ot_s;
  logic               frame_start, frame_done, sclk_rise, sclk_fall, in_frame;
  logic [FRAME_W-1:0] frame_word, rb_value;
  logic               rb_load, ldac_fall, clr_fall;

  dsf_sync #(.W(6), .STAGES(SYNC_STAGES), .RST_VAL(6'b110110)) u_sync (
    .clk(clk), .rst(rst),
    .d({sclk, sync_n, sdi, ldac_n, clr_n, over_temp}),
    .q({sclk_s, sync_s, sdi_s, ldac_s, clr_s, ot_s})
  );

  dsf_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .sync_s(sync_s), .sdi_s(sdi_s),
    .frame_start(frame_start), .frame_done(frame_done), .frame_word(frame_word),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .in_frame(in_frame)
  );

  dsf_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_word(frame_word),
    .ldac_s(ldac_s), .clr_s(clr_s), .dac_code(dac_code), .ctrl_word(ctrl_word),
    .rb_load(rb_load), .rb_value(rb_value), .ldac_fall(ldac_fall), .clr_fall(clr_fall)
  );

  dsf_readback #(.FRAME_W(FRAME_W)) u_rb (
    .clk(clk), .rst(rst), .rb_load(rb_load), .rb_value(rb_value),
    .frame_start(frame_start), .in_frame(in_frame), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .sdo(sdo)
  );

  always_ff @(posedge clk) begin
    if (rst) alarm_n <= 1'b1;
    else     alarm_n <= ~ot_s;
  end
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker #(
  parameter int DATA_W = 12,
  parameter int FRAME_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               sdo,
  input logic               alarm_n,
  input logic [DATA_W-1:0]  dac_code,
  input logic [DATA_W-1:0]  ctrl_word,
  input logic               sync_s,
  input logic               ldac_s,
  input logic               clr_s,
  input logic               ot_s,
  input logic               frame_done,
  input logic [FRAME_W-1:0] frame_word,
  input logic               clr_fall
);
  // R6: a clear edge leaves the converter code at zero
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr_fall |=> (dac_code == '0));

  // R7: holding clear freezes the converter code
  a_r7_clear_blocks_load: assert property (@(posedge clk) disable iff (rst)
    (!clr_s && !clr_fall) |=> $stable(dac_code));

  // R8: control word moves only after a completed frame
  a_r8_ctrl_only_on_frame: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_word) |-> $past(frame_done));

  // R5: strobe held low makes a write reach the code at once
  a_r5_direct_update: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_word[FRAME_W-1 -: 4] == 4'h1 && !ldac_s && clr_s && !clr_fall)
    |=> (dac_code == $past(frame_word[DATA_W-1:0])));

  // R11: no data on the return line while deselected
  a_r11_sdo_idle: assert property (@(posedge clk) disable iff (rst)
    (sync_s && $past(sync_s)) |-> !sdo);

  // R12: alarm follows the synchronized indication
  a_r12_alarm_on: assert property (@(posedge clk) disable iff (rst)
    $rose(ot_s) |=> !alarm_n);
  a_r12_alarm_off: assert property (@(posedge clk) disable iff (rst)
    $fell(ot_s) |=> alarm_n);
endmodule

bind dac_serial_front dsf_checker #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst(rst), .sdo(sdo), .alarm_n(alarm_n), .dac_code(dac_code),
  .ctrl_word(ctrl_word), .sync_s(sync_s), .ldac_s(ldac_s), .clr_s(clr_s),
  .ot_s(ot_s), .frame_done(frame_done), .frame_word(frame_word), .clr_fall(clr_fall)
);

// File: tb/sim_dac_serial_front.sv
module sim_dac_serial_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b1, sync_n = 1'b1, sdi = 1'b0;
  logic        ldac_n = 1'b1, clr_n = 1'b1, over_temp = 1'b0;
  logic        sdo, alarm_n;
  logic [11:0] dac_code, ctrl_word;
  int          vectors = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  dac_serial_front u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdi(sdi), .sdo(sdo),
    .ldac_n(ldac_n), .clr_n(clr_n), .over_temp(over_temp), .alarm_n(alarm_n),
    .dac_code(dac_code), .ctrl_word(ctrl_word)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // nbits bits: the first 16 come from w, MSB first; any extras come from ext
  task automatic frame(input logic [15:0] w, input int nbits, input logic [1:0] ext,
                       output logic [15:0] rd);
    rd = '0;
    sync_n = 1'b0;
    tick(8);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : ext[i-16];
      tick(4);
      if (i < 16) rd[15-i] = sdo;
      sclk = 1'b0;
      tick(8);
      sclk = 1'b1;
      tick(4);
    end
    tick(4);
    sync_n = 1'b1;
    sdi = 1'b0;
    tick(10);
  endtask

  task automatic send(input logic [15:0] w);
    logic [15:0] dummy;
    frame(w, 16, 2'b00, dummy);
  endtask

  task automatic pulse_ldac();
    ldac_n = 1'b0;
    tick(6);
    ldac_n = 1'b1;
    tick(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [11:0] v, prev, cw;
    logic [15:0] rd;
    tick(5);
    rst = 1'b0;
    tick(5);
    // R1 reset state
    check("R1 dac", {4'h0, dac_code}, 16'h0000);
    check("R1 ctrl", {4'h0, ctrl_word}, 16'h0000);
    check("R1 sdo", {15'h0, sdo}, 16'h0000);
    check("R1 alarm", {15'h0, alarm_n}, 16'h0001);

    // R2 staging writes do not reach the code; R4 strobe moves them
    prev = 12'h000;
    for (int k = 0; k < 12; k++) begin
      v = 12'((k * 16'h02A7 + 16'h0015) & 16'h0FFF);
      send({4'h1, v});
      check("R2 staged only", {4'h0, dac_code}, {4'h0, prev});
      pulse_ldac();
      check("R4 strobe load", {4'h0, dac_code}, {4'h0, v});
      prev = v;
    end

    // R3 frames cut short are dropped
    for (int n = 1; n < 16; n += 7) begin
      frame({4'h1, 12'hABC}, n, 2'b00, rd);
      pulse_ldac();
      check("R3 abort", {4'h0, dac_code}, {4'h0, prev});
    end
    frame({4'h2, 12'hABC}, 15, 2'b00, rd);
    check("R3 abort ctrl", {4'h0, ctrl_word}, 16'h0000);

    // R8 control writes, R10 control readback
    for (int k = 0; k < 4; k++) begin
      cw = 12'((k * 16'h0513 + 16'h00A3) & 16'h0FFF);
      send({4'h2, cw});
      check("R8 ctrl write", {4'h0, ctrl_word}, {4'h0, cw});
      send({4'hA, 12'h000});
      frame(16'h0000, 16, 2'b00, rd);
      check("R10 ctrl readback", rd, {4'h0, cw});
    end

    // R9 code readback, MSB first, zero-extended
    for (int k = 0; k < 4; k++) begin
      v = 12'((k * 16'h0BCD + 16'h0F0F) & 16'h0FFF);
      send({4'h1, v});
      pulse_ldac();
      send({4'h9, 12'hFFF});
      frame(16'h0000, 16, 2'b00, rd);
      check("R9 dac readback", rd, {4'h0, v});
      prev = v;
    end

    // R11 nothing queued: line stays low through a frame
    frame(16'h0000, 16, 2'b00, rd);
    check("R11 no pending", rd, 16'h0000);
    check("R11 idle", {15'h0, sdo}, 16'h0000);

    // R13 unassigned codes change nothing
    send({4'h1, 12'h321});
    send({4'h5, 12'h777});
    send({4'hF, 12'hEEE});
    check("R13 dac", {4'h0, dac_code}, {4'h0, prev});
    check("R13 ctrl", {4'h0, ctrl_word}, {4'h0, cw});
    pulse_ldac();
    check("R13 staging kept", {4'h0, dac_code}, 16'h0321);

    // R5 strobe held low: direct update
    ldac_n = 1'b0;
    tick(8);
    for (int k = 0; k < 4; k++) begin
      v = 12'((k * 16'h0357 + 16'h0101) & 16'h0FFF);
      send({4'h1, v});
      check("R5 direct", {4'h0, dac_code}, {4'h0, v});
    end
    ldac_n = 1'b1;
    tick(8);

    // R14 extra clock edges ignored
    frame({4'h1, 12'h0F0}, 18, 2'b11, rd);
    pulse_ldac();
    check("R14 extra edges", {4'h0, dac_code}, 16'h00F0);

    // R6 clear zeroes both registers
    send({4'h1, 12'h9AB});
    pulse_ldac();
    send({4'h1, 12'h5CD});
    clr_n = 1'b0;
    tick(8);
    check("R6 clear code", {4'h0, dac_code}, 16'h0000);
    clr_n = 1'b1;
    tick(8);
    pulse_ldac();
    check("R6 clear staging", {4'h0, dac_code}, 16'h0000);

    // R7 strobe ignored under clear, staging still writable
    clr_n = 1'b0;
    tick(8);
    send({4'h1, 12'h456});
    pulse_ldac();
    check("R7 strobe ignored", {4'h0, dac_code}, 16'h0000);
    clr_n = 1'b1;
    tick(8);
    check("R7 release", {4'h0, dac_code}, 16'h0000);
    pulse_ldac();
    check("R7 staged during clear", {4'h0, dac_code}, 16'h0456);

    // R12 alarm
    over_temp = 1'b1;
    tick(6);
    check("R12 alarm on", {15'h0, alarm_n}, 16'h0000);
    over_temp = 1'b0;
    tick(6);
    check("R12 alarm off", {15'h0, alarm_n}, 16'h0001);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule